// File: doc/BRIEF.md
# Power-Up Write Inhibit Guard

This block stands between the strobe pins of an electrically erasable memory and its write engine. It decides, one clock at a time, whether a write may begin. A write is refused while a digital supply-good flag is low. It is also refused for a fixed hold-off after that flag rises, and while the output-enable level is asserted. A write strobe (chip-enable and write-enable both low) must also stay qualified for a minimum number of clocks before the block accepts it, so that narrow glitches are rejected.

All strobe inputs are active-low levels already synchronous to the clock. The supply threshold crossing arrives as a digital flag. The hold-off length and the filter width are parameters counted in clock cycles. The output is a single-clock write-start pulse for each accepted strobe, plus a level that reports whether writes are currently inhibited. Every pin is a plain control or status signal, and there is no data path or handshake.

Top module: `pwr_write_guard`

## Requirements
- R1: While rst_n is low, wr_start is 0 and inhibit is 1, and the hold-off timer is cleared.
- R2: In any cycle where supply_ok is low at the clock edge, no write-start pulse follows, and inhibit is 1.
- R3: Writes are armed only after supply_ok has been sampled high on HOLD_CYC consecutive clock edges. Until then inhibit is 1 and no write-start is produced.
- R4: A single low sample of supply_ok clears the hold-off timer, so another HOLD_CYC consecutive high samples are needed before writes are armed again.
- R5: While oe_n is low (0), inhibit is 1, and the qualified strobe run is broken so that no write-start follows that edge.
- R6: While cs_n is 1 or we_n is 1 there is no strobe, so no write-start follows. These levels alone do not raise inhibit.
- R7: A strobe counts as qualified on an edge when writes are armed, oe_n=1, cs_n=0 and we_n=0. A run shorter than FILT_CYC consecutive qualified edges produces no write-start.
- R8: wr_start is high for exactly one clock for each qualified run. A run held longer than FILT_CYC produces no second pulse until the run is broken.
- R9: wr_start rises in the clock that follows the FILT_CYC-th consecutive qualified edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above the write threshold |
| cs_n | input | 1 | Chip-enable level, active low |
| oe_n | input | 1 | Output-enable level, active low |
| we_n | input | 1 | Write-enable level, active low |
| wr_start | output | 1 | One-clock write-start pulse |
| inhibit | output | 1 | 1 while writes are blocked by supply, hold-off or output-enable |

## Verification
The bench holds a strobe low across the end of the hold-off. A timer off by one would release the write one clock early or late, and the start pulse would then move. Runs of length FILT_CYC-1 and FILT_CYC are driven next to each other, so a filter that compares against the wrong bound either passes the glitch or drops the good strobe. A one-cycle supply dip after arming checks that the timer restarts rather than resumes. A long held strobe catches a design that retriggers while it saturates. Random level sequences then cover oe_n and supply changes in the middle of a run.

// File: rtl/guard_pkg.sv
package guard_pkg;
  // Active-low strobe levels sampled each clock
  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } strobe_lv_t;

  function automatic logic strobe_low(strobe_lv_t s);
    return !s.cs_n && !s.we_n;
  endfunction
endpackage

// File: rtl/por_holdoff.sv
module por_holdoff #(
  parameter int HOLD_CYC = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic ready
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!supply_ok)     cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == LIMIT);
endmodule

// File: rtl/strobe_filter.sv
module strobe_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  output logic start
);
  localparam int WW = $clog2(FILT_CYC + 1);
  localparam logic [WW-1:0] FULL = WW'(FILT_CYC);
  localparam logic [WW-1:0] LAST = WW'(FILT_CYC - 1);

  logic [WW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      start <= 1'b0;
    end else if (qual) begin
      start <= (run == LAST);
      if (run != FULL) run <= run + 1'b1;
    end else begin
      run   <= '0;
      start <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_write_guard.sv
module pwr_write_guard #(
  parameter int HOLD_CYC = 1_000_000,
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_start,
  output logic inhibit
);
  import guard_pkg::*;

  logic       hold_done;
  logic       armed;
  logic       qual;
  strobe_lv_t lv;

  assign lv = '{cs_n: cs_n, oe_n: oe_n, we_n: we_n};

  por_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ready(hold_done)
  );

  assign armed   = supply_ok && hold_done;
  assign qual    = armed && lv.oe_n && strobe_low(lv);
  assign inhibit = !armed || !lv.oe_n;

  strobe_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .qual(qual), .start(wr_start)
  );
endmodule

// File: rtl/pwr_write_guard_chk.sv
module pwr_write_guard_chk #(
  parameter int HOLD_CYC = 1_000_000,
  parameter int FILT_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic cs_n,
  input logic oe_n,
  input logic we_n,
  input logic wr_start,
  input logic inhibit
);
  int sup_run;
  int stb_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_run <= 0;
      stb_run <= 0;
    end else begin
      sup_run <= supply_ok ? ((sup_run < HOLD_CYC) ? sup_run + 1 : sup_run) : 0;
      stb_run <= (supply_ok && oe_n && !cs_n && !we_n) ?
                 ((stb_run < FILT_CYC) ? stb_run + 1 : stb_run) : 0;
    end
  end

  // R2
  supply_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !wr_start);
  // R3
  holdoff_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit |-> sup_run >= HOLD_CYC);
  // R5
  oe_low_inhibits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> inhibit);
  // R5
  oe_low_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> !wr_start);
  // R6
  no_strobe_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || we_n) |=> !wr_start);
  // R7
  filter_width_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> stb_run >= FILT_CYC);
  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);
endmodule

bind pwr_write_guard pwr_write_guard_chk #(.HOLD_CYC(HOLD_CYC), .FILT_CYC(FILT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n), .oe_n(oe_n),
  .we_n(we_n), .wr_start(wr_start), .inhibit(inhibit)
);

// File: tb/pwr_write_guard_bench.sv
module pwr_write_guard_bench;
  localparam int HOLD = 40;
  localparam int FILT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic wr_start, inhibit;

  int checks = 0, fails = 0, pulses = 0;
  int m_cnt = 0, m_w = 0;
  logic exp_start = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwr_write_guard #(.HOLD_CYC(HOLD), .FILT_CYC(FILT)) u_pwr_write_guard (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n), .oe_n(oe_n),
    .we_n(we_n), .wr_start(wr_start), .inhibit(inhibit)
  );

  function automatic logic exp_inhibit(logic s, logic o, int cnt);
    return !s || (cnt < HOLD) || !o;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic s, logic c, logic o, logic w);
    logic q;
    @(negedge clk);
    check(tag, "wr_start", wr_start, exp_start);
    if (wr_start) pulses++;
    supply_ok = s; cs_n = c; oe_n = o; we_n = w;
    #1;
    check(tag, "inhibit", inhibit, exp_inhibit(s, o, m_cnt));
    q = s && (m_cnt == HOLD) && o && !c && !w;
    exp_start = q && (m_w == FILT - 1);
    m_w   = q ? ((m_w < FILT) ? m_w + 1 : m_w) : 0;
    m_cnt = s ? ((m_cnt < HOLD) ? m_cnt + 1 : m_cnt) : 0;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic strobe(string tag, int len);
    for (int i = 0; i < len; i++) step(tag, 1'b1, 1'b0, 1'b1, 1'b0);
    step(tag, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200_000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int p0;
    void'($urandom(1234));
    #7;
    // R1: reset state
    check("R1", "wr_start", wr_start, 1'b0);
    check("R1", "inhibit", inhibit, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // R2: supply low with strobe held
    for (int i = 0; i < 10; i++) step("R2", 1'b0, 1'b0, 1'b1, 1'b0);

    // R3 / R9: strobe held across end of hold-off, exactly one start
    p0 = pulses;
    for (int i = 0; i < HOLD + 10; i++) step("R3", 1'b1, 1'b0, 1'b1, 1'b0);
    step("R3", 1'b1, 1'b1, 1'b1, 1'b1);
    check("R8", "pulse count", (pulses - p0) == 1, 1'b1);

    // R7 / R9: runs of 1, 2, FILT
    strobe("R7", 1); idle("R7", 2);
    strobe("R7", FILT - 1); idle("R7", 2);
    p0 = pulses;
    strobe("R9", FILT); idle("R9", 2);
    check("R9", "pulse count", (pulses - p0) == 1, 1'b1);

    // R8: long strobe, one pulse; broken then repeated gives a second
    p0 = pulses;
    strobe("R8", 20); strobe("R8", FILT); idle("R8", 2);
    check("R8", "pulse count", (pulses - p0) == 2, 1'b1);

    // R6: cs high or we high while other low
    for (int i = 0; i < 6; i++) step("R6", 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step("R6", 1'b1, 1'b0, 1'b1, 1'b1);

    // R5: output-enable low during strobe
    for (int i = 0; i < 6; i++) step("R5", 1'b1, 1'b0, 1'b0, 1'b0);
    step("R5", 1'b1, 1'b0, 1'b1, 1'b0);
    step("R5", 1'b1, 1'b0, 1'b0, 1'b0);
    idle("R5", 2);

    // R4: one-cycle supply dip restarts the full hold-off
    step("R4", 1'b0, 1'b1, 1'b1, 1'b1);
    p0 = pulses;
    for (int i = 0; i < HOLD + 8; i++) step("R4", 1'b1, 1'b0, 1'b1, 1'b0);
    idle("R4", 2);
    check("R4", "pulse count", (pulses - p0) == 1, 1'b1);

    // Random levels, biased toward armed long strobes
    for (int i = 0; i < 4000; i++) begin
      logic s, c, o, w;
      string tag;
      s = ($urandom_range(0, 199) != 0);
      c = ($urandom_range(0, 3) == 0);
      w = ($urandom_range(0, 3) == 0);
      o = ($urandom_range(0, 9) != 0);
      if (!s) tag = "R2";
      else if (m_cnt < HOLD) tag = "R3";
      else if (!o) tag = "R5";
      else if (c || w) tag = "R6";
      else tag = "R7";
      step(tag, s, c, o, w);
    end
    idle("R8", 3);
    finish_run();
  end
endmodule